// File: doc/BRIEF.md
# Disk Channel Interrupt Status and Clear Unit

This unit gathers the two interrupt causes of a single disk-interface channel: a completion request raised by the attached drive and a memory-side fault reported by the DMA engine. Each cause is held in a sticky status flag. A per-cause enable mask decides which flags may drive the single level-sensitive interrupt line toward the host.

Software reaches the unit through a word-addressed register port. One location reads the flags, and writing ones to it clears those flags. Two further locations set and clear enable bits. When a memory fault is flagged, the unit also captures the failing address, which software can read back as two data words. Typical use is as follows. At initialisation, software writes 0x03 to the enable-set location. When the interrupt arrives, it reads the status word and, if a fault is flagged, the address words. It then writes 0x03 to the status location to acknowledge both causes.

Top module: `ata_irq_unit`

## Requirements
- R1: After reset every flag, every enable bit and the captured address are zero, and irq_o is low.
- R2: A cycle with dev_evt_i high sets flag bit 0 at the next clock edge, and a cycle with bus_err_i high sets flag bit 1. A flag stays set until software clears it.
- R3: A read of byte offset 0x0C returns the device flag in bit 0 and the fault flag in bit 1, with all other bits zero.
- R4: A write to byte offset 0x0C clears each flag whose write-data bit is 1 (bit 0 device, bit 1 fault). Flags whose bit is written 0 keep their value, so writing 0x03 clears both.
- R5: If an event arrives in the same cycle as a write that clears its flag, the flag stays set.
- R6: A write to byte offset 0x14 sets the enable bits written as 1, and a write to byte offset 0x1C clears the enable bits written as 1 (bit 0 device, bit 1 fault). A read of either offset returns the enable mask in bits 1:0, and data bits above bit 1 are ignored.
- R7: irq_o is high exactly when some flag and its enable bit are both 1. It follows the stored state with no extra register stage.
- R8: When bus_err_i is high, bus_err_addr_i is captured if the fault flag is clear or is being cleared in that cycle. The low data word of the captured address reads at byte offset 0x00 and the high word at byte offset 0x04.
- R9: While the fault flag stays set, further faults leave the captured address unchanged. Clearing the flag also leaves it unchanged until the next capture.
- R10: Writes to the address words or to any unmapped offset change no state. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register write strobe qualifier |
| reg_we_i | input | 1 | Write enable for the current access |
| reg_addr_i | input | ADDR_W (8) | Byte address, word aligned |
| reg_wdata_i | input | DATA_W (32) | Write data |
| reg_rdata_o | output | DATA_W (32) | Read data for reg_addr_i, combinational |
| dev_evt_i | input | 1 | Drive interrupt event |
| bus_err_i | input | 1 | Memory-side DMA fault event |
| bus_err_addr_i | input | ERR_ADDR_W (64) | Address of the faulting access |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The bench builds the unit with a 32-bit data word, an 8-bit byte address and a 64-bit fault address. With these values the captured address splits across two readable words, so both halves can be checked separately. An event can also land on the same edge as its clear. Distinct patterns are written into the address halves, which exposes swapped or stale words, and the mask is driven through partial set and clear writes so that each flag and its enable can be shown to gate the line independently.

// File: rtl/ata_irq_pkg.sv
package ata_irq_pkg;
  localparam int NUM_SRC  = 2;
  localparam int SRC_DEV  = 0;
  localparam int SRC_ERR  = 1;
  // word indices; software layout depends on these
  localparam int IDX_ERR0 = 0;
  localparam int IDX_STAT = 3;
  localparam int IDX_ESET = 5;
  localparam int IDX_ECLR = 7;
endpackage

// File: rtl/ata_irq_decode.sv
module ata_irq_decode
  import ata_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [WORD_W-1:0]  word_o,
  output logic [NUM_SRC-1:0] flag_clr_o,
  output logic [NUM_SRC-1:0] en_set_o,
  output logic [NUM_SRC-1:0] en_clr_o
);
  logic wr;
  logic unused_bits;

  assign word_o = addr_i[ADDR_W-1:2];
  assign wr     = req_i & we_i;

  always_comb begin
    flag_clr_o = '0;
    en_set_o   = '0;
    en_clr_o   = '0;
    if (wr) begin
      if (word_o == WORD_W'(IDX_STAT)) flag_clr_o = wdata_i[NUM_SRC-1:0];
      if (word_o == WORD_W'(IDX_ESET)) en_set_o   = wdata_i[NUM_SRC-1:0];
      if (word_o == WORD_W'(IDX_ECLR)) en_clr_o   = wdata_i[NUM_SRC-1:0];
    end
  end

  assign unused_bits = ^{addr_i[1:0], wdata_i[DATA_W-1:NUM_SRC]};
endmodule

// File: rtl/ata_irq_flags.sv
module ata_irq_flags
  import ata_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] flag_clr_i,
  input  logic [NUM_SRC-1:0] en_set_i,
  input  logic [NUM_SRC-1:0] en_clr_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic [NUM_SRC-1:0] enable_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic st_q, en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q <= 1'b0;
        en_q <= 1'b0;
      end else begin
        // new event beats a same-cycle clear
        st_q <= evt_i[i] | (st_q & ~flag_clr_i[i]);
        if (en_set_i[i])      en_q <= 1'b1;
        else if (en_clr_i[i]) en_q <= 1'b0;
      end
    end
    assign status_o[i] = st_q;
    assign enable_o[i] = en_q;
  end
endmodule

// File: rtl/ata_irq_err_cap.sv
module ata_irq_err_cap #(
  parameter int ERR_ADDR_W = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  err_evt_i,
  input  logic                  err_flag_i,
  input  logic                  err_clr_i,
  input  logic [ERR_ADDR_W-1:0] err_addr_i,
  output logic [ERR_ADDR_W-1:0] err_addr_o
);
  logic                  capture;
  logic [ERR_ADDR_W-1:0] addr_q;

  // first fault after an acknowledge owns the address
  assign capture = err_evt_i & (~err_flag_i | err_clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (capture) addr_q <= err_addr_i;
  end

  assign err_addr_o = addr_q;
endmodule

// File: rtl/ata_irq_unit.sv
module ata_irq_unit
  import ata_irq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int ERR_ADDR_W = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_req_i,
  input  logic                  reg_we_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  input  logic                  dev_evt_i,
  input  logic                  bus_err_i,
  input  logic [ERR_ADDR_W-1:0] bus_err_addr_i,
  output logic                  irq_o
);
  localparam int WORD_W    = ADDR_W - 2;
  localparam int ERR_WORDS = ERR_ADDR_W / DATA_W;

  logic [WORD_W-1:0]     word;
  logic [NUM_SRC-1:0]    flag_clr, en_set, en_clr, evt;
  logic [NUM_SRC-1:0]    status_q, enable_q;
  logic [ERR_ADDR_W-1:0] err_addr_q;

  assign evt[SRC_DEV] = dev_evt_i;
  assign evt[SRC_ERR] = bus_err_i;

  ata_irq_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .req_i      (reg_req_i),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .word_o     (word),
    .flag_clr_o (flag_clr),
    .en_set_o   (en_set),
    .en_clr_o   (en_clr)
  );

  ata_irq_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .flag_clr_i (flag_clr),
    .en_set_i   (en_set),
    .en_clr_i   (en_clr),
    .status_o   (status_q),
    .enable_o   (enable_q)
  );

  ata_irq_err_cap #(.ERR_ADDR_W(ERR_ADDR_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .err_evt_i  (bus_err_i),
    .err_flag_i (status_q[SRC_ERR]),
    .err_clr_i  (flag_clr[SRC_ERR]),
    .err_addr_i (bus_err_addr_i),
    .err_addr_o (err_addr_q)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int k = 0; k < ERR_WORDS; k++) begin
      if (word == WORD_W'(IDX_ERR0 + k)) reg_rdata_o = err_addr_q[k*DATA_W +: DATA_W];
    end
    if (word == WORD_W'(IDX_STAT)) reg_rdata_o[NUM_SRC-1:0] = status_q;
    if (word == WORD_W'(IDX_ESET) || word == WORD_W'(IDX_ECLR))
      reg_rdata_o[NUM_SRC-1:0] = enable_q;
  end

  assign irq_o = |(status_q & enable_q);
endmodule

// File: rtl/ata_irq_chk.sv
module ata_irq_chk
  import ata_irq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int ERR_ADDR_W = 64
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  reg_req_i,
  input logic                  reg_we_i,
  input logic [ADDR_W-1:0]     reg_addr_i,
  input logic [DATA_W-1:0]     reg_wdata_i,
  input logic                  dev_evt_i,
  input logic                  bus_err_i,
  input logic                  irq_o,
  input logic [NUM_SRC-1:0]    status_q,
  input logic [NUM_SRC-1:0]    enable_q,
  input logic [ERR_ADDR_W-1:0] err_addr_q
);
  localparam int WORD_W = ADDR_W - 2;
  logic [WORD_W-1:0] w;
  logic wr, st_wr, set_wr;
  assign w      = reg_addr_i[ADDR_W-1:2];
  assign wr     = reg_req_i & reg_we_i;
  assign st_wr  = wr && (w == WORD_W'(IDX_STAT));
  assign set_wr = wr && (w == WORD_W'(IDX_ESET));

  // R2
  dev_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_evt_i |=> status_q[SRC_DEV]);
  // R5
  err_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_err_i && st_wr && reg_wdata_i[SRC_ERR]) |=> status_q[SRC_ERR]);
  // R4
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && reg_wdata_i[SRC_DEV] && !dev_evt_i) |=> !status_q[SRC_DEV]);
  // R6
  enable_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_wr && reg_wdata_i[SRC_ERR]) |=> enable_q[SRC_ERR]);
  // R7
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|status_q) && (|enable_q));
  // R9
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q[SRC_ERR] && !(st_wr && reg_wdata_i[SRC_ERR])) |=> $stable(err_addr_q));
endmodule

bind ata_irq_unit ata_irq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERR_ADDR_W(ERR_ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_req_i   (reg_req_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .dev_evt_i   (dev_evt_i),
  .bus_err_i   (bus_err_i),
  .irq_o       (irq_o),
  .status_q    (status_q),
  .enable_q    (enable_q),
  .err_addr_q  (err_addr_q)
);

// File: tb/ata_irq_unit_test.sv
`timescale 1ns/1ps
module ata_irq_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        dev = 1'b0, err = 1'b0, irq;
  logic [63:0] eaddr = '0;

  int checks = 0, errors = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t exp_q[$];
  event  smp_ev;

  always #4 clk = ~clk;

  ata_irq_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .dev_evt_i(dev), .bus_err_i(err), .bus_err_addr_i(eaddr), .irq_o(irq)
  );

  // monitor: pops expected items and compares
  initial forever begin
    @(smp_ev);
    while (exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = exp_q.pop_front();
      act = it.is_irq ? {31'b0, irq} : rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic cyc(input bit do_wr, input logic [7:0] a, input logic [31:0] d,
                     input logic de, input logic ee, input logic [63:0] ea);
    @(negedge clk);
    req = do_wr; we = do_wr; addr = a; wdata = d;
    dev = de; err = ee; eaddr = ea;
    @(negedge clk);
    req = 1'b0; we = 1'b0; dev = 1'b0; err = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0, '0);
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    addr = a;
    exp_q.push_back('{1'b0, e, tag});
    #2 -> smp_ev;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    exp_q.push_back('{1'b1, {31'b0, e}, tag});
    #2 -> smp_ev;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_rd(8'h0C, 32'h0, "R1 status");
    chk_rd(8'h14, 32'h0, "R1 enable");
    chk_rd(8'h00, 32'h0, "R1 addr lo");
    chk_rd(8'h04, 32'h0, "R1 addr hi");
    chk_irq(1'b0, "R1 irq");
    // R2 / R3 device event, masked
    cyc(1'b0, 8'h0, 32'h0, 1'b1, 1'b0, '0);
    chk_rd(8'h0C, 32'h1, "R2 R3 dev flag");
    chk_irq(1'b0, "R7 masked");
    // R6 enable both
    wr(8'h14, 32'h3);
    chk_rd(8'h14, 32'h3, "R6 set read");
    chk_rd(8'h1C, 32'h3, "R6 clr read");
    chk_irq(1'b1, "R7 enabled");
    // R4 clearing
    wr(8'h0C, 32'h0);
    chk_rd(8'h0C, 32'h1, "R4 zero write");
    wr(8'h0C, 32'h3);
    chk_rd(8'h0C, 32'h0, "R4 clear both");
    chk_irq(1'b0, "R7 after clear");
    // R8 capture
    cyc(1'b0, 8'h0, 32'h0, 1'b0, 1'b1, 64'hDEAD_BEEF_1234_5678);
    chk_rd(8'h0C, 32'h2, "R2 err flag");
    chk_rd(8'h00, 32'h1234_5678, "R8 addr lo");
    chk_rd(8'h04, 32'hDEAD_BEEF, "R8 addr hi");
    chk_irq(1'b1, "R7 err irq");
    // R9 later fault ignored
    cyc(1'b0, 8'h0, 32'h0, 1'b0, 1'b1, 64'h1111_1111_2222_2222);
    chk_rd(8'h00, 32'h1234_5678, "R9 hold lo");
    chk_rd(8'h04, 32'hDEAD_BEEF, "R9 hold hi");
    // R10 writes with no effect
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    chk_rd(8'h00, 32'h1234_5678, "R10 addr write");
    chk_rd(8'h08, 32'h0, "R10 unmapped 08");
    chk_rd(8'h18, 32'h0, "R10 unmapped 18");
    chk_rd(8'h0C, 32'h2, "R10 status kept");
    chk_rd(8'h14, 32'h3, "R10 enable kept");
    // R6 partial clear of enable
    wr(8'h1C, 32'h2);
    chk_rd(8'h14, 32'h1, "R6 partial clr");
    chk_irq(1'b0, "R7 err masked");
    // R5 clear racing a new fault; R8 recapture
    cyc(1'b1, 8'h0C, 32'h2, 1'b0, 1'b1, 64'h0000_00AA_0000_00BB);
    chk_rd(8'h0C, 32'h2, "R5 err wins");
    chk_rd(8'h00, 32'h0000_00BB, "R8 recapture lo");
    chk_rd(8'h04, 32'h0000_00AA, "R8 recapture hi");
    cyc(1'b1, 8'h0C, 32'h1, 1'b1, 1'b0, '0);
    chk_rd(8'h0C, 32'h3, "R5 dev wins");
    chk_irq(1'b1, "R7 dev irq");
    // R4 single-bit clears; R9 retention
    wr(8'h0C, 32'h1);
    chk_rd(8'h0C, 32'h2, "R4 clear dev only");
    chk_irq(1'b0, "R7 dev cleared");
    wr(8'h0C, 32'h2);
    chk_rd(8'h0C, 32'h0, "R4 clear err");
    chk_rd(8'h00, 32'h0000_00BB, "R9 kept after clear");
    // R6 upper bits ignored
    wr(8'h14, 32'hFFFF_FFFF);
    chk_rd(8'h1C, 32'h3, "R6 wide set");
    // R8 capture after acknowledge
    cyc(1'b0, 8'h0, 32'h0, 1'b0, 1'b1, 64'h0BAD_F00D_CAFE_0001);
    chk_rd(8'h04, 32'h0BAD_F00D, "R8 fresh hi");
    chk_irq(1'b1, "R7 err enabled");
    #20;
    if (exp_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard: actual=%0d expected=0 pending", exp_q.size());
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule